// File: doc/BRIEF.md
# Dual-Address Four-Location Bit Memory

This block stores four independent bits, each picked by a two-bit location index. Writing and reading use separate address inputs. Each side therefore has its own decode path, and the write logic can be released while a read is still in progress.

A write is phased. The `unlock` input opens the write gate. While the gate is open, a `push` with `din` high sets the addressed location, and an `erase` clears it. A push with `din` low leaves the location where it was. A push sent while the gate is closed changes nothing and sets a sticky error flag.

The read side works as a sum of products over the four locations. The first register stage holds one AND term per location, and the second stage holds their NOR. The output `rd_n` is the inverse of the selected bit and is valid two clock edges after the read address is presented.

Top module: `rod_mem4x1`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rd_n` is 1, `err` is 0, and all four locations hold 0.
- R2: If `unlock`=1, `push`=1, `din`=1 and `erase`=0, the location whose index equals `wr_addr` (0..3, with bit 1 as the high address bit) reads 1 from the next edge on. No other location changes.
- R3: A push with `din`=0 leaves the addressed location unchanged, so a stored 1 stays 1 and a 0 stays 0.
- R4: While `unlock`=0, neither push nor erase changes any location, and an erase with the gate closed does not set `err`.
- R5: A push with `unlock`=0 sets `err` at the next edge. `err` then stays 1 until reset.
- R6: If `unlock`=1 and `erase`=1, the addressed location becomes 0. Erase overrides a push in the same cycle.
- R7: `rd_n` sampled after two rising edges equals the inverse of the bit at the location given by `rd_addr` before the first of those edges.
- R8: If a read and a write target the same location in the same cycle, the read returns the value stored before that write.
- R9: `rd_addr` is decoded separately from `wr_addr`. A write to one location never changes a read of a different location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unlock | input | 1 | Opens the write gate |
| push | input | 1 | Write attempt that sets the location when `din` is 1 |
| erase | input | 1 | Clears the addressed location while the gate is open |
| din | input | 1 | Data offered by a push |
| wr_addr | input | ADDR_W | Write location index |
| rd_addr | input | ADDR_W | Read location index |
| rd_n | output | 1 | Inverted read data, two-edge latency |
| err | output | 1 | Sticky flag for a push with the gate closed |

## Verification
The bench targets four cases:
- A read and a write to the same location in the same cycle. A design that forwards the new value would return the wrong bit there.
- An erase and a push in the same cycle. Giving push priority would leave a stale 1.
- Pushes with `din` low. A design that writes `din` directly would clear a stored 1.
- Pushes with the gate closed. A design that set `err` for a closed-gate erase, or let `err` drop again, would differ from the reference model on the following cycles.

Long mixed stretches with independent read and write addresses also expose any off-by-one in the two-stage read latency.

// File: rtl/rm_pkg.sv
package rm_pkg;

    localparam int RM_ADDR_W = 2;

    typedef struct packed {
        logic unlock;
        logic push;
        logic erase;
        logic din;
    } wr_ctl_t;

    // a push attempted with the gate closed is a protocol error
    function automatic logic closed_push(input wr_ctl_t c);
        return c.push & ~c.unlock;
    endfunction

    // set request for one location once it is known to be addressed
    function automatic logic set_req(input wr_ctl_t c);
        return c.unlock & c.push & c.din & ~c.erase;
    endfunction

endpackage

// File: rtl/rm_wr_bank.sv
module rm_wr_bank
    import rm_pkg::*;
#(
    parameter int ADDR_W = RM_ADDR_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_ctl_t           ctl,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [DEPTH-1:0]  st_q,
    output logic              err_q
);

    always_ff @(posedge clk) begin
        if (rst)                   err_q <= 1'b0;
        else if (closed_push(ctl)) err_q <= 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_loc
        logic hit;
        assign hit = ctl.unlock && (wr_addr == ADDR_W'(i));

        always_ff @(posedge clk) begin
            if (rst)                       st_q[i] <= 1'b0;
            else if (hit && ctl.erase)     st_q[i] <= 1'b0;
            else if (hit && set_req(ctl))  st_q[i] <= 1'b1;
        end

        // R4
        untouched_loc_chk: assert property (@(posedge clk) disable iff (rst)
            !(ctl.unlock && wr_addr == ADDR_W'(i)) |=> $stable(st_q[i]));
        // R2
        set_loc_chk: assert property (@(posedge clk) disable iff (rst)
            (ctl.unlock && ctl.push && ctl.din && !ctl.erase && wr_addr == ADDR_W'(i)) |=> st_q[i]);
        // R6
        erase_loc_chk: assert property (@(posedge clk) disable iff (rst)
            (ctl.unlock && ctl.erase && wr_addr == ADDR_W'(i)) |=> !st_q[i]);
        // R3
        zero_push_chk: assert property (@(posedge clk) disable iff (rst)
            (ctl.push && !ctl.din && !ctl.erase) |=> $stable(st_q[i]));
    end

    // R5
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.push && !ctl.unlock) |=> err_q);
    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

endmodule

// File: rtl/rm_rd_and.sv
module rm_rd_and
    import rm_pkg::*;
#(
    parameter int ADDR_W = RM_ADDR_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DEPTH-1:0]  st,
    output logic [DEPTH-1:0]  term_q
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_term
        always_ff @(posedge clk) begin
            if (rst) term_q[i] <= 1'b0;
            else     term_q[i] <= st[i] && (rd_addr == ADDR_W'(i));
        end
    end

    // R9
    single_term_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(term_q));

endmodule

// File: rtl/rm_rd_nor.sv
module rm_rd_nor #(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] term,
    output logic             rd_n_q
);

    always_ff @(posedge clk) begin
        if (rst) rd_n_q <= 1'b1;
        else     rd_n_q <= ~|term;
    end

endmodule

// File: rtl/rod_mem4x1.sv
module rod_mem4x1
    import rm_pkg::*;
#(
    parameter int ADDR_W = RM_ADDR_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              unlock,
    input  logic              push,
    input  logic              erase,
    input  logic              din,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_n,
    output logic              err
);

    wr_ctl_t          ctl;
    logic [DEPTH-1:0] st;
    logic [DEPTH-1:0] term;

    assign ctl = '{unlock: unlock, push: push, erase: erase, din: din};

    rm_wr_bank #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst(rst), .ctl(ctl), .wr_addr(wr_addr),
        .st_q(st), .err_q(err)
    );

    rm_rd_and #(.ADDR_W(ADDR_W)) u_and (
        .clk(clk), .rst(rst), .rd_addr(rd_addr), .st(st), .term_q(term)
    );

    rm_rd_nor #(.DEPTH(DEPTH)) u_nor (
        .clk(clk), .rst(rst), .term(term), .rd_n_q(rd_n)
    );

    // latency window guard for the end-to-end read check
    logic [1:0] warm_q;
    logic       sel_bit;
    assign sel_bit = st[rd_addr];

    always_ff @(posedge clk) begin
        if (rst)                 warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R7
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (rd_n == !$past(sel_bit, 2)));
    // R1
    reset_out_chk: assert property (@(posedge clk)
        $past(rst) |-> (rd_n && !err));

endmodule

// File: tb/rod_mem4x1_tb.sv
`timescale 1ns/1ps
module rod_mem4x1_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       unlock, push, erase, din;
    logic [1:0] wr_addr, rd_addr;
    logic       rd_n, err;

    always #2.5 clk = ~clk;

    rod_mem4x1 dut_i (
        .clk(clk), .rst(rst), .unlock(unlock), .push(push), .erase(erase),
        .din(din), .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_n(rd_n), .err(err)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    m_st[4];
    bit    m_s1;
    bit    m_rdn;
    bit    m_err;
    string tag;
    bit    done = 0;

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit u, input bit p, input bit e, input bit d,
                        input int wa, input int ra);
        unlock = u; push = p; erase = e; din = d;
        wr_addr = 2'(wa); rd_addr = 2'(ra);
        @(posedge clk);
        m_rdn = !m_s1;
        m_s1  = m_st[ra];
        if (!u && p) m_err = 1'b1;
        if (u && e)           m_st[wa] = 1'b0;
        else if (u && p && d) m_st[wa] = 1'b1;
        @(negedge clk);
        chk(rd_n, m_rdn, tag, "rd_n");
        chk(err, m_err, (tag == "R4") ? "R4" : "R5", "err");
    endtask

    task automatic do_reset();
        rst = 1'b1; unlock = 0; push = 0; erase = 0; din = 0;
        wr_addr = 0; rd_addr = 0;
        repeat (2) @(negedge clk);
        chk(rd_n, 1'b1, "R1", "rd_n in reset");
        chk(err, 1'b0, "R1", "err in reset");
        rst = 1'b0;
        foreach (m_st[k]) m_st[k] = 1'b0;
        m_s1 = 1'b0; m_rdn = 1'b1; m_err = 1'b0;
    endtask

    // read every location back, two idle steps each for latency
    task automatic read_all(input string req);
        tag = req;
        for (int a = 0; a < 4; a++) begin
            step(0, 0, 0, 0, 0, a);
            step(0, 0, 0, 0, 0, a);
        end
    endtask

    initial begin
        do_reset();
        tag = "R1";
        step(0, 0, 0, 0, 0, 0);
        read_all("R1");

        // R2: set location 2 only
        tag = "R2";
        step(1, 1, 0, 1, 2, 0);
        read_all("R2");

        // R3: push with din low keeps 1 at loc 2 and 0 at loc 1
        tag = "R3";
        step(1, 1, 0, 0, 2, 2);
        step(1, 1, 0, 0, 1, 1);
        read_all("R3");

        // R6: erase wins over push; then plain erase
        tag = "R6";
        step(1, 1, 0, 1, 3, 3);
        step(1, 1, 1, 1, 3, 3);
        step(1, 0, 1, 0, 2, 2);
        read_all("R6");

        // R8: read and write the same location in one cycle
        tag = "R8";
        step(1, 1, 0, 1, 1, 1);
        step(0, 0, 0, 0, 0, 1);
        step(1, 0, 1, 0, 1, 1);
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1);

        // R9: write loc 0 while reading loc 3 repeatedly
        tag = "R9";
        step(1, 1, 0, 1, 3, 3);
        for (int n = 0; n < 6; n++) step(1, 1, n[0], 1, 0, 3);
        read_all("R9");

        // R4: closed-gate erase neither clears nor flags
        tag = "R4";
        step(0, 0, 1, 0, 3, 3);
        read_all("R4");

        // R5: closed-gate push flags and is ignored; flag sticks
        tag = "R5";
        step(0, 1, 0, 1, 1, 1);
        for (int n = 0; n < 4; n++) step(1, 0, 0, 0, 0, n);
        read_all("R5");

        // R7: long mixed traffic compared cycle by cycle
        do_reset();
        tag = "R7";
        for (int n = 0; n < 2000; n++)
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 3), $urandom_range(0, 3));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule